// File: doc/BRIEF.md
# Authenticated Mode Entry Controller

This controller decides when a small processor core may run with secure privilege. Software describes one signed code window with a base address and a length. A branch that lands anywhere inside that window starts an entry attempt. The core is stalled while an external MAC engine hashes the window. The engine's result is then compared with the expected value that the core keeps in its sixth crypto register.

When the two values match, the controller grants authenticated mode. It also redirects the program counter to the start of the window, so that signed code is always entered at its first instruction. It keeps the computed MAC as the saved signature, and a clear-signature operation can later wipe that signature. When the values differ, the controller raises a one-cycle failure pulse and the branch goes ahead without privilege.

Authenticated code has to announce its exit by writing the mode-control register before it fetches from outside the window. A fetch from outside the window without that write stops the core permanently, until the next reset.

Top module: `auth_entry_ctrl`

## Requirements
- R1: After reset the controller is in normal mode: stall, mac_req, auth_mode, halted, pc_load and auth_fail are low, and saved_sig is zero.
- R2: In normal mode, a branch whose target t satisfies 0 <= t - region_base < region_len (16-bit unsigned difference, no wrap) drives stall high in the same cycle and raises mac_req from the next cycle until mac_done. A branch outside that window, or any branch when region_len is 0, has no effect.
- R3: When mac_done arrives with mac_value equal to expected_mac, auth_mode goes high in the next cycle. In that same cycle pc_load pulses for exactly one cycle with pc_value equal to region_base, whatever the branch target was.
- R4: When mac_done arrives with a mismatching mac_value, the next cycle shows a one-cycle auth_fail pulse, auth_mode low, pc_load low, and mac_req and stall low.
- R5: On a successful entry, saved_sig takes the value of mac_value in the same cycle that auth_mode rises.
- R6: An op_valid cycle with op_code 8'hE0 sets saved_sig to zero in the next cycle. Any other op_code leaves saved_sig unchanged. A clear in the same cycle as a successful entry wins over the latch.
- R7: A mode_wr pulse in authenticated mode arms the exit. A later fetch_valid with fetch_addr outside the window then returns the controller to normal mode, without a halt.
- R8: A fetch outside the window in authenticated mode without a prior mode_wr sets halted in the next cycle. Halted holds, with stall high and no new mac_req, until reset.
- R9: A mode_wr given outside authenticated mode does not arm a later exit.
- R10: Branches into the window during authenticated mode do not start a new MAC request. Fetches inside the window keep authenticated mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| region_base | input | 16 | First address of the signed window |
| region_len | input | 16 | Window length in address units |
| branch_valid | input | 1 | Branch taken this cycle |
| branch_target | input | 16 | Branch destination address |
| fetch_valid | input | 1 | Instruction fetch this cycle |
| fetch_addr | input | 16 | Fetch address |
| expected_mac | input | 32 | Expected MAC held in crypto register 6 |
| mac_req | output | 1 | Request to the MAC engine, held until done |
| mac_done | input | 1 | MAC engine result valid |
| mac_value | input | 32 | Computed MAC |
| mode_wr | input | 1 | Write strobe of the mode-control register |
| op_valid | input | 1 | Crypto operation issued |
| op_code | input | 8 | Crypto operation byte (8'hE0 clears the signature) |
| stall | output | 1 | Holds the core |
| pc_load | output | 1 | One-cycle program counter redirect |
| pc_value | output | 16 | Redirect address |
| auth_mode | output | 1 | Authenticated privilege active |
| auth_fail | output | 1 | One-cycle MAC mismatch pulse |
| halted | output | 1 | Core halted after an exit violation |
| saved_sig | output | 32 | Saved signature of the last successful entry |

## Verification
Window membership is tried with branch targets one below the base, at the base, at the last address, one past the end and in the middle. It is also tried with an empty window and with a window that ends at the top of the address space, which separates a correct unsigned-difference test from off-by-one or wrapping compares. Each hit is closed with a mismatching MAC, which shows that a failure pulse leaves no privilege behind. Matching entries from a mid-window target show that the redirect is to the base and not to the target. Exits with and without the mode write, and with a write made too early outside authenticated mode, separate the clean return path from the halt.

// File: rtl/auth_pkg.sv
package auth_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_HASHING = 2'd1,
    ST_AUTH    = 2'd2,
    ST_HALTED  = 2'd3
  } amode_e;

  localparam logic [7:0] OP_SIG_CLEAR = 8'hE0;
endpackage

// File: rtl/auth_region_cmp.sv
module auth_region_cmp #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  function automatic logic in_window(input logic [AW-1:0] a,
                                     input logic [AW-1:0] b,
                                     input logic [AW-1:0] l);
    logic [AW-1:0] off;
    off = a - b;
    return (a >= b) && (off < l);
  endfunction

  assign hit = in_window(addr, base, len);
endmodule

// File: rtl/auth_sig_store.sv
module auth_sig_store #(
  parameter int MW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [MW-1:0] load_val,
  input  logic          clr,
  output logic [MW-1:0] sig
);
  always_ff @(posedge clk) begin
    if (!rst_n)     sig <= '0;
    else if (clr)   sig <= '0;
    else if (load)  sig <= load_val;
  end

  // R6
  sig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sig == '0));
  // R5
  sig_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (sig == $past(load_val)));
endmodule

// File: rtl/auth_mode_fsm.sv
module auth_mode_fsm
  import auth_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          branch_hit,
  input  logic          fetch_out,
  input  logic          mode_wr,
  input  logic          mac_done,
  input  logic          mac_match,
  input  logic [AW-1:0] region_base,
  output amode_e        st,
  output logic          armed,
  output logic          entry_ok,
  output logic          pc_load,
  output logic [AW-1:0] pc_value,
  output logic          auth_fail
);
  assign entry_ok = (st == ST_HASHING) && mac_done && mac_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_NORMAL;
      armed     <= 1'b0;
      pc_load   <= 1'b0;
      pc_value  <= '0;
      auth_fail <= 1'b0;
    end else begin
      pc_load   <= 1'b0;
      auth_fail <= 1'b0;
      case (st)
        ST_NORMAL: begin
          armed <= 1'b0;
          if (branch_hit) st <= ST_HASHING;
        end
        ST_HASHING: begin
          if (mac_done) begin
            if (mac_match) begin
              st       <= ST_AUTH;
              pc_load  <= 1'b1;
              pc_value <= region_base;
            end else begin
              st        <= ST_NORMAL;
              auth_fail <= 1'b1;
            end
          end
        end
        ST_AUTH: begin
          if (fetch_out) begin
            st    <= armed ? ST_NORMAL : ST_HALTED;
            armed <= 1'b0;
          end else if (mode_wr) begin
            armed <= 1'b1;
          end
        end
        default: st <= ST_HALTED;
      endcase
    end
  end

  // R2
  entry_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_NORMAL && branch_hit) |=> (st == ST_HASHING));
  // R3
  redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (st == ST_AUTH));
  // R4
  fail_no_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auth_fail |-> (st == ST_NORMAL));
  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HALTED) |=> (st == ST_HALTED));
  // R8
  exit_violation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_AUTH && fetch_out && !armed) |=> (st == ST_HALTED));
  // R7
  clean_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_AUTH && fetch_out && armed) |=> (st == ST_NORMAL));
endmodule

// File: rtl/auth_entry_ctrl.sv
module auth_entry_ctrl
  import auth_pkg::*;
#(
  parameter int AW = 16,
  parameter int MW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] region_base,
  input  logic [AW-1:0] region_len,
  input  logic          branch_valid,
  input  logic [AW-1:0] branch_target,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic [MW-1:0] expected_mac,
  output logic          mac_req,
  input  logic          mac_done,
  input  logic [MW-1:0] mac_value,
  input  logic          mode_wr,
  input  logic          op_valid,
  input  logic [7:0]    op_code,
  output logic          stall,
  output logic          pc_load,
  output logic [AW-1:0] pc_value,
  output logic          auth_mode,
  output logic          auth_fail,
  output logic          halted,
  output logic [MW-1:0] saved_sig
);
  logic   br_in, fe_in, branch_hit, fetch_out, entry_ok, armed, sig_clr;
  amode_e st;

  auth_region_cmp #(.AW(AW)) u_br_cmp (
    .base(region_base), .len(region_len), .addr(branch_target), .hit(br_in));
  auth_region_cmp #(.AW(AW)) u_fe_cmp (
    .base(region_base), .len(region_len), .addr(fetch_addr), .hit(fe_in));

  assign branch_hit = branch_valid && br_in;
  assign fetch_out  = fetch_valid && !fe_in;
  assign sig_clr    = op_valid && (op_code == OP_SIG_CLEAR);

  auth_mode_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .branch_hit(branch_hit), .fetch_out(fetch_out),
    .mode_wr(mode_wr), .mac_done(mac_done), .mac_match(mac_value == expected_mac),
    .region_base(region_base), .st(st), .armed(armed), .entry_ok(entry_ok),
    .pc_load(pc_load), .pc_value(pc_value), .auth_fail(auth_fail));

  auth_sig_store #(.MW(MW)) u_sig (
    .clk(clk), .rst_n(rst_n), .load(entry_ok), .load_val(mac_value),
    .clr(sig_clr), .sig(saved_sig));

  assign mac_req   = (st == ST_HASHING);
  assign auth_mode = (st == ST_AUTH);
  assign halted    = (st == ST_HALTED);
  assign stall     = mac_req || halted || ((st == ST_NORMAL) && branch_hit);

  // R2
  req_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mac_req |-> stall);
  // R10
  no_rehash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auth_mode |=> !mac_req);
  // R9
  arm_only_auth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> auth_mode);
endmodule

// File: tb/auth_entry_ctrl_test.sv
`timescale 1ns/1ps
module auth_entry_ctrl_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] region_base = '0, region_len = '0, branch_target = '0, fetch_addr = '0;
  logic        branch_valid = 0, fetch_valid = 0, mac_done = 0, mode_wr = 0, op_valid = 0;
  logic [31:0] expected_mac = 32'hCAFE_F00D, mac_value = '0;
  logic [7:0]  op_code = '0;
  logic        mac_req, stall, pc_load, auth_mode, auth_fail, halted;
  logic [15:0] pc_value;
  logic [31:0] saved_sig;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  auth_entry_ctrl uut (.*);

  localparam int NV = 7;
  // base, len, target, expected hit
  localparam logic [48:0] VEC [NV] = '{
    {16'h1000, 16'h0100, 16'h0FFF, 1'b0},
    {16'h1000, 16'h0100, 16'h1000, 1'b1},
    {16'h1000, 16'h0100, 16'h10FF, 1'b1},
    {16'h1000, 16'h0100, 16'h1100, 1'b0},
    {16'h1000, 16'h0100, 16'h1080, 1'b1},
    {16'h2000, 16'h0000, 16'h2000, 1'b0},
    {16'hFF00, 16'h0100, 16'hFFFF, 1'b1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic branch(input logic [15:0] t, output logic st_now);
    branch_valid = 1; branch_target = t;
    #1 st_now = stall;
    cyc();
    branch_valid = 0;
  endtask

  task automatic finish_mac(input logic [31:0] v);
    mac_done = 1; mac_value = v;
    cyc();
    mac_done = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; cyc(); cyc(); rst_n = 1;
  endtask

  task automatic enter_ok(input logic [15:0] t);
    logic s;
    branch(t, s);
    finish_mac(expected_mac);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic s;
    cyc();
    do_reset();
    // R1 reset state
    chk("R1 stall", stall, 0); chk("R1 mac_req", mac_req, 0);
    chk("R1 auth_mode", auth_mode, 0); chk("R1 halted", halted, 0);
    chk("R1 pc_load", pc_load, 0); chk("R1 auth_fail", auth_fail, 0);
    chk("R1 saved_sig", saved_sig, 0);

    // R2 window membership table, R4 mismatch closes each hit
    for (int i = 0; i < NV; i++) begin
      region_base = VEC[i][48:33]; region_len = VEC[i][32:17];
      branch(VEC[i][16:1], s);
      chk("R2 stall same cycle", s, VEC[i][0]);
      chk("R2 mac_req next cycle", mac_req, VEC[i][0]);
      if (VEC[i][0]) begin
        chk("R2 stall held", stall, 1);
        finish_mac(32'h0BAD_0BAD);
        chk("R4 auth_fail pulse", auth_fail, 1);
        chk("R4 no privilege", auth_mode, 0);
        chk("R4 no redirect", pc_load, 0);
        chk("R4 req dropped", mac_req, 0);
        chk("R4 stall dropped", stall, 0);
        cyc();
        chk("R4 pulse one cycle", auth_fail, 0);
      end
    end

    // R3/R5 successful entry from mid-window target
    region_base = 16'h1000; region_len = 16'h0100;
    enter_ok(16'h1040);
    chk("R3 auth_mode", auth_mode, 1);
    chk("R3 pc_load", pc_load, 1);
    chk("R3 pc_value base", pc_value, 16'h1000);
    chk("R5 saved_sig", saved_sig, 32'hCAFE_F00D);
    cyc();
    chk("R3 pc_load one cycle", pc_load, 0);

    // R10 branch in AUTH, fetch inside window
    branch(16'h1010, s);
    chk("R10 no mac_req", mac_req, 0);
    fetch_valid = 1; fetch_addr = 16'h10F0; cyc(); fetch_valid = 0;
    chk("R10 stays auth", auth_mode, 1);

    // R7 armed exit
    mode_wr = 1; cyc(); mode_wr = 0;
    fetch_valid = 1; fetch_addr = 16'h3000; cyc(); fetch_valid = 0;
    chk("R7 left auth", auth_mode, 0);
    chk("R7 not halted", halted, 0);

    // R6 clear signature
    op_valid = 1; op_code = 8'h5A; cyc(); op_valid = 0;
    chk("R6 other op no effect", saved_sig, 32'hCAFE_F00D);
    op_valid = 1; op_code = 8'hE0; cyc(); op_valid = 0;
    chk("R6 clear", saved_sig, 0);

    // R6 clear wins over simultaneous latch
    branch(16'h1000, s);
    op_valid = 1; op_code = 8'hE0;
    finish_mac(expected_mac);
    op_valid = 0;
    chk("R6 clear priority auth", auth_mode, 1);
    chk("R6 clear priority sig", saved_sig, 0);
    fetch_valid = 1; fetch_addr = 16'h1001; cyc(); fetch_valid = 0;
    mode_wr = 1; cyc(); mode_wr = 0;
    fetch_valid = 1; fetch_addr = 16'h0000; cyc(); fetch_valid = 0;
    chk("R7 second exit", halted, 0);

    // R9 early write in NORMAL, then R8 halt
    mode_wr = 1; cyc(); mode_wr = 0;
    expected_mac = 32'h1234_5678;
    enter_ok(16'h10FF);
    chk("R5 new sig", saved_sig, 32'h1234_5678);
    fetch_valid = 1; fetch_addr = 16'h2000; cyc(); fetch_valid = 0;
    chk("R9 early write ignored, halted", halted, 1);
    chk("R8 stall while halted", stall, 1);
    chk("R8 no auth", auth_mode, 0);
    branch(16'h1000, s);
    cyc(); cyc();
    chk("R8 no mac_req halted", mac_req, 0);
    chk("R8 sticky", halted, 1);
    do_reset();
    chk("R8 reset clears halt", halted, 0);
    chk("R1 stall after reset", stall, 0);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule